// File: doc/BRIEF.md
# Power and System Control Unit

This unit holds the power-control and system-control registers of an 8-bit microcontroller core. It also derives the clock enables that put the CPU and the peripherals to sleep. Software reaches both registers through the special-function-register port. Setting the light-sleep bit stops the CPU clock but leaves the oscillator domain, the timers and the interrupt logic running. Any interrupt request then wakes the CPU by clearing that bit in hardware. Setting the deep-sleep bit stops the peripheral domain as well. Only a reset brings the chip out of deep sleep, and register contents are kept until that reset arrives.

The same unit produces the address-latch strobe. This is a free-running square wave at one sixth of the oscillator rate, and a control bit can silence it to reduce emissions. The unit also turns the watchdog-overflow pulse into the system reset. It keeps a flag that tells software a watchdog reset happened, and that flag survives the watchdog reset itself. A serial-rate doubling bit is exported to the UART baud logic.

Top module: `pwr_sys_ctrl`

## Requirements
- R1: When `rst_ext` or `wdt_ovf` is high at a clock edge, every register bit other than the watchdog flag returns to 0. After that edge `cpu_clk_en` and `periph_clk_en` are 1 and `ale` is low. `sys_rst` is 1 in the cycle after each such edge and 0 otherwise.
- R2: A write of 1 to bit 0 (light sleep) of the power register at address 87h makes `cpu_clk_en` 0 from the next cycle. `periph_clk_en` stays 1.
- R3: While light sleep is set, a high `irq` clears bit 0 at that edge, unless a write to 87h happens in the same cycle. `cpu_clk_en` returns to 1 in the next cycle.
- R4: A write of 1 to bit 1 (deep sleep) of address 87h makes both clock enables 0. While deep sleep is set, `irq` and writes to 87h have no effect. Only R1 resets end deep sleep.
- R5: When bits 0 and 1 are both written as 1, only deep sleep is set, and bit 0 reads back as 0.
- R6: Bit 7 of 87h drives `smod`. Bits 2 and 3 of 87h are general-purpose flags that read back as written.
- R7: Bits 4 to 6 of 87h and bits 1 to 6 of BFh read as 0, and writes to them are ignored. Any other address reads 0, and `sfr_rdata` is 0 while `sfr_rd` is low.
- R8: Bit 7 of the system register at BFh is the watchdog flag. `wdt_ovf` sets it, and the reset caused by `wdt_ovf` does not clear it. `rst_ext` clears it. A write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged.
- R9: The internal strobe toggles every 3 clock cycles, giving a period of 6, starting low after reset. It holds its phase while deep sleep is set.
- R10: Bit 0 of BFh set to 1 forces `ale` low. The strobe phase keeps advancing underneath, so `ale` resumes in phase when the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_ext | input | 1 | External synchronous reset, active high |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wdata | input | 8 | Write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read enable |
| sfr_rdata | output | 8 | Read data |
| irq | input | 1 | Pending interrupt request |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| ale | output | 1 | Address-latch strobe |
| smod | output | 1 | Serial baud doubling |
| sys_rst | output | 1 | System reset, one cycle after the reset cause |

## Verification
The hardest situations to reach are the ones stacked on top of deep sleep. Examples are a watchdog overflow arriving while the chip is frozen, an interrupt or a register write that must be ignored there, and the strobe phase that must resume exactly where it stopped. The bench drives these in order through the port: it enters deep sleep and then fires `irq` and writes. It counts frozen cycles before pulsing `wdt_ovf`. It then checks the preserved flag and the restarted phase. A cycle-accurate reference model compares every output on every clock. Randomised register traffic then mixes writes, reads, interrupts and resets.

// File: rtl/pwr_sys_pkg.sv
package pwr_sys_pkg;

    localparam int SFR_W = 8;

    // Bit positions inside the power register
    localparam int PB_LIGHT = 0;
    localparam int PB_DEEP  = 1;
    localparam int PB_FLAG0 = 2;
    localparam int PB_FLAG1 = 3;
    localparam int PB_BAUD2 = 7;

    // Bit positions inside the system register
    localparam int SB_MUTE  = 0;
    localparam int SB_WDOG  = 7;

    typedef struct packed {
        logic baud2;
        logic flag1;
        logic flag0;
        logic deep;
        logic light;
    } pwr_reg_t;

    typedef struct packed {
        logic wdog;
        logic mute;
    } sys_reg_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_LIGHT = 2'd1,
        MODE_DEEP  = 2'd2
    } pwr_mode_e;

    function automatic logic [SFR_W-1:0] pwr_to_byte(pwr_reg_t r);
        logic [SFR_W-1:0] b;
        b = '0;
        b[PB_LIGHT] = r.light;
        b[PB_DEEP]  = r.deep;
        b[PB_FLAG0] = r.flag0;
        b[PB_FLAG1] = r.flag1;
        b[PB_BAUD2] = r.baud2;
        return b;
    endfunction

    function automatic pwr_reg_t byte_to_pwr(logic [SFR_W-1:0] b);
        pwr_reg_t r;
        r.baud2 = b[PB_BAUD2];
        r.flag1 = b[PB_FLAG1];
        r.flag0 = b[PB_FLAG0];
        r.deep  = b[PB_DEEP];
        // deep sleep wins over light sleep
        r.light = b[PB_LIGHT] & ~b[PB_DEEP];
        return r;
    endfunction

    function automatic logic [SFR_W-1:0] sys_to_byte(sys_reg_t r);
        logic [SFR_W-1:0] b;
        b = '0;
        b[SB_MUTE] = r.mute;
        b[SB_WDOG] = r.wdog;
        return b;
    endfunction

endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
    import pwr_sys_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  pwr_reg_t  wr_val,
    input  logic      irq,
    output pwr_reg_t  q,
    output pwr_mode_e mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!q.deep) begin
            if (wr_en)
                q <= wr_val;
            else if (q.light && irq)
                q.light <= 1'b0;
        end
    end

    always_comb begin
        if (q.deep)       mode = MODE_DEEP;
        else if (q.light) mode = MODE_LIGHT;
        else              mode = MODE_RUN;
    end

    AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (rst)
        (q.light && irq && !wr_en) |=> !q.light); // R3
    AST_DEEP_STICKS: assert property (@(posedge clk) disable iff (rst)
        q.deep |=> (q.deep && $stable(q.baud2) && $stable(q.flag0))); // R4
    AST_ONE_SLEEP: assert property (@(posedge clk) disable iff (rst)
        !(q.light && q.deep)); // R5

endmodule

// File: rtl/sys_ctl_reg.sv
module sys_ctl_reg
    import pwr_sys_pkg::*;
(
    input  logic     clk,
    input  logic     rst_ext,
    input  logic     wdt_ovf,
    input  logic     wr_en,
    input  logic     wr_mute,
    input  logic     wr_wdog,
    output sys_reg_t q
);

    always_ff @(posedge clk) begin
        if (rst_ext) begin
            q <= '0;
        end else if (wdt_ovf) begin
            q.mute <= 1'b0;
            q.wdog <= 1'b1;
        end else if (wr_en) begin
            q.mute <= wr_mute;
            if (!wr_wdog)
                q.wdog <= 1'b0;
        end
    end

    AST_WDOG_SET: assert property (@(posedge clk) disable iff (rst_ext)
        wdt_ovf |=> q.wdog); // R8
    AST_WDOG_KEEP: assert property (@(posedge clk) disable iff (rst_ext)
        (q.wdog && !wdt_ovf && !(wr_en && !wr_wdog)) |=> q.wdog); // R8

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tog
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (HALF == 1) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst)      tog <= 1'b0;
                else if (run) tog <= ~tog;
            end
        end else begin : g_count
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                    tog <= 1'b0;
                end else if (run) begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        tog <= ~tog;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    endgenerate

    AST_STROBE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(tog)); // R9

endmodule

// File: rtl/pwr_sys_ctrl.sv
module pwr_sys_ctrl
    import pwr_sys_pkg::*;
#(
    parameter logic [SFR_W-1:0] PWR_ADDR = 8'h87,
    parameter logic [SFR_W-1:0] SYS_ADDR = 8'hBF,
    parameter int               ALE_HALF = 3
) (
    input  logic             clk,
    input  logic             rst_ext,
    input  logic [SFR_W-1:0] sfr_addr,
    input  logic [SFR_W-1:0] sfr_wdata,
    input  logic             sfr_wr,
    input  logic             sfr_rd,
    output logic [SFR_W-1:0] sfr_rdata,
    input  logic             irq,
    input  logic             wdt_ovf,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             ale,
    output logic             smod,
    output logic             sys_rst
);

    logic      rst_all;
    logic      pwr_wr;
    logic      sys_wr;
    pwr_reg_t  pwr_q;
    sys_reg_t  sys_q;
    pwr_mode_e mode;
    logic      strobe;
    logic      rst_q;

    assign rst_all = rst_ext | wdt_ovf;
    assign pwr_wr  = sfr_wr && (sfr_addr == PWR_ADDR);
    assign sys_wr  = sfr_wr && (sfr_addr == SYS_ADDR);

    pwr_mode_reg u_pwr (
        .clk    (clk),
        .rst    (rst_all),
        .wr_en  (pwr_wr),
        .wr_val (byte_to_pwr(sfr_wdata)),
        .irq    (irq),
        .q      (pwr_q),
        .mode   (mode)
    );

    sys_ctl_reg u_sys (
        .clk     (clk),
        .rst_ext (rst_ext),
        .wdt_ovf (wdt_ovf),
        .wr_en   (sys_wr),
        .wr_mute (sfr_wdata[SB_MUTE]),
        .wr_wdog (sfr_wdata[SB_WDOG]),
        .q       (sys_q)
    );

    strobe_gen #(.HALF(ALE_HALF)) u_strobe (
        .clk (clk),
        .rst (rst_all),
        .run (mode != MODE_DEEP),
        .tog (strobe)
    );

    always_ff @(posedge clk) begin
        rst_q <= rst_all;
    end

    always_comb begin
        sfr_rdata = '0;
        if (sfr_rd) begin
            case (sfr_addr)
                PWR_ADDR: sfr_rdata = pwr_to_byte(pwr_q);
                SYS_ADDR: sfr_rdata = sys_to_byte(sys_q);
                default:  sfr_rdata = '0;
            endcase
        end
    end

    assign cpu_clk_en    = (mode == MODE_RUN);
    assign periph_clk_en = (mode != MODE_DEEP);
    assign ale           = strobe & ~sys_q.mute;
    assign smod          = pwr_q.baud2;
    assign sys_rst       = rst_q;

    AST_MUTE_SILENCES: assert property (@(posedge clk) disable iff (rst_all)
        sys_q.mute |-> !ale); // R10
    AST_WAKE_ENABLES: assert property (@(posedge clk) disable iff (rst_all)
        (mode == MODE_LIGHT && irq && !sfr_wr) |=> cpu_clk_en); // R3
    AST_RESET_PULSE: assert property (@(posedge clk)
        rst_all |=> (sys_rst && cpu_clk_en && periph_clk_en)); // R1

endmodule

// File: tb/tb_pwr_sys_ctrl.sv
module tb_pwr_sys_ctrl;

    logic       clk = 1'b0;
    logic       rst_ext = 1'b1;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_wr = 1'b0;
    logic       sfr_rd = 1'b1;
    logic [7:0] sfr_rdata;
    logic       irq = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       cpu_clk_en, periph_clk_en, ale, smod, sys_rst;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwr_sys_ctrl dut (
        .clk(clk), .rst_ext(rst_ext), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .irq(irq),
        .wdt_ovf(wdt_ovf), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .ale(ale), .smod(smod), .sys_rst(sys_rst)
    );

    // Behavioural reference model
    int m_light = 0, m_deep = 0, m_baud = 0, m_f0 = 0, m_f1 = 0;
    int m_wdog = 0, m_mute = 0, m_phase = 0, m_rst = 0;

    always @(posedge clk) begin
        cycles = cycles + 1;
        m_rst = (rst_ext || wdt_ovf) ? 1 : 0;
        if (rst_ext || wdt_ovf) begin
            m_light = 0; m_deep = 0; m_baud = 0; m_f0 = 0; m_f1 = 0;
            m_mute = 0; m_phase = 0;
            m_wdog = rst_ext ? 0 : 1;
        end else begin
            if (m_deep == 0) m_phase = (m_phase + 1) % 6;
            if (sfr_wr && sfr_addr == 8'h87 && m_deep == 0) begin
                m_baud = sfr_wdata[7]; m_f1 = sfr_wdata[3]; m_f0 = sfr_wdata[2];
                m_deep = sfr_wdata[1];
                m_light = (sfr_wdata[0] && !sfr_wdata[1]) ? 1 : 0;
            end else if (irq && m_light == 1 && m_deep == 0) begin
                m_light = 0;
            end
            if (sfr_wr && sfr_addr == 8'hBF) begin
                m_mute = sfr_wdata[0];
                if (!sfr_wdata[7]) m_wdog = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    task automatic check_all();
        int exp_rd;
        exp_rd = 0;
        if (sfr_rd && sfr_addr == 8'h87)
            exp_rd = m_baud * 128 + m_f1 * 8 + m_f0 * 4 + m_deep * 2 + m_light;
        else if (sfr_rd && sfr_addr == 8'hBF)
            exp_rd = m_wdog * 128 + m_mute;
        chk("R2/R3 cpu_clk_en", cpu_clk_en, (m_light == 0 && m_deep == 0) ? 1 : 0);
        chk("R4 periph_clk_en", periph_clk_en, (m_deep == 0) ? 1 : 0);
        chk("R9/R10 ale", ale, (m_phase >= 3 && m_mute == 0) ? 1 : 0);
        chk("R6 smod", smod, m_baud);
        chk("R1 sys_rst", sys_rst, m_rst);
        chk("R7/R8 sfr_rdata", sfr_rdata, exp_rd);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        step(1);
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        sfr_addr = a;
        step(1);
    endtask

    task automatic pulse_wdt();
        wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
    endtask

    task automatic pulse_rst();
        rst_ext = 1'b1; step(1); rst_ext = 1'b0;
    endtask

    initial begin : watchdog
        wait (cycles > 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);                           // R1 reset state
        rst_ext = 1'b0;
        rd(8'h87); rd(8'hBF); step(8);     // R9 free-running strobe
        wr(8'h87, 8'h8C); rd(8'h87);       // R6 baud and flags
        wr(8'h87, 8'h70); rd(8'h87);       // R7 unused bits dropped
        rd(8'h55);                         // R7 other address
        sfr_rd = 1'b0; rd(8'h87); sfr_rd = 1'b1;
        wr(8'h87, 8'h01); step(4);         // R2 light sleep
        irq = 1'b1; step(1); irq = 1'b0;   // R3 wake
        rd(8'h87); step(2);
        wr(8'h87, 8'h83); rd(8'h87);       // R5 both bits -> deep
        irq = 1'b1; step(2); irq = 1'b0;   // R4 irq ignored
        wr(8'h87, 8'h00); step(7);         // R4 write ignored, R9 frozen
        pulse_rst(); rd(8'h87); step(4);   // R4 reset exits
        wr(8'hBF, 8'h01); step(8);         // R10 mute
        wr(8'hBF, 8'h00); step(6);
        wr(8'h87, 8'h84);
        pulse_wdt(); rd(8'hBF); rd(8'h87); // R8 flag kept, R1 regs cleared
        wr(8'hBF, 8'h81); rd(8'hBF);       // R8 write 1 keeps
        wr(8'hBF, 8'h7E); rd(8'hBF);       // R8 write 0 clears, R7 unused
        pulse_wdt(); pulse_rst(); rd(8'hBF); // R8 external reset clears
        wr(8'h87, 8'h02); step(5);
        pulse_wdt(); rd(8'hBF); step(6);   // R8 watchdog ends deep sleep
        for (int k = 0; k < 1500; k++) begin
            int r;
            r = $urandom % 100;
            sfr_addr = (r < 45) ? 8'h87 : ((r < 85) ? 8'hBF : 8'($urandom));
            sfr_wdata = 8'($urandom);
            sfr_wr = ($urandom % 4) == 0;
            sfr_rd = ($urandom % 8) != 0;
            irq = ($urandom % 5) == 0;
            wdt_ovf = ($urandom % 60) == 0;
            rst_ext = ($urandom % 90) == 0;
            step(1);
        end
        sfr_wr = 1'b0; irq = 1'b0; wdt_ovf = 1'b0; rst_ext = 1'b0;
        step(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule